// File: doc/BRIEF.md
# Memory Region Permission Checker

This block decides whether one memory access may go ahead, given a set of protection regions whose bounds have already been decoded into inclusive low and high byte addresses. Each request carries a byte address, a byte count, the wanted read/write/execute rights and whether the requester runs at machine level. The block scans the regions by index, picks the first one that decides the access, and returns a pass/deny flag plus the rights mask that applied. The result is registered and appears one clock after the request.

Two policy flavours are supported, picked at run time by two security inputs. The standard flavour grants machine level everything in an unlocked region and otherwise applies the region's own rights. The lockdown flavour looks the rights up in one of two sixteen-row tables keyed by the region's lock and rights bits, one table for machine level and one for lower levels. A separate restrictive bit turns every unmatched access into a denial.

Top module: `pmp_access_checker`

## Requirements
- R1: `resp_valid` equals `req_valid` of the previous clock; `resp_allow` and `resp_perm` take the result of a request one clock after it and hold their values while `req_valid` is low.
- R2: A clock with `rst` high clears `resp_valid`, `resp_allow` and `resp_perm` to zero.
- R3: Regions are scanned from index 0 upward and the lowest-index region that decides the access alone sets the result.
- R4: A region decides with a denial (allow 0, mask 0) when exactly one of the first and last access bytes lies inside its inclusive bounds; this holds whatever its match-mode field.
- R5: A region matches only when both bytes lie inside its bounds and its match-mode field (config bits [4:3]) is nonzero; a region with mode 0 and both bytes inside is skipped.
- R6: Lockdown bit low: the mask is RWX for a matched region with lock bit (config bit 5) clear at machine level, and otherwise the region's rights bits (config bit 0 R, bit 1 W, bit 2 X).
- R7: Lockdown bit high, machine level: with index L*8+R*4+W*2+X, rows 2,3,14 give RW, rows 9,10 give X, rows 11,13 give RX, rows 12,15 give R, all other rows give nothing.
- R8: Lockdown bit high, lower level: rows 1,10,11 give X, rows 2,4,15 give R, rows 3,6 give RW, row 5 gives RX, row 7 gives RWX, all other rows give nothing.
- R9: On a match the access passes exactly when every requested right (`req_perm` bit 0 R, bit 1 W, bit 2 X) is in the mask.
- R10: With no deciding region and the restrictive bit high, the access is denied with mask 0.
- R11: With no deciding region, restrictive bit low and lockdown bit high, a machine-level request without X passes with mask RW; every other request is denied with mask 0.
- R12: With no deciding region and both security bits low, machine level passes with mask RWX and lower levels are denied with mask 0.
- R13: When `rule_count` is zero no region is consulted and the default of R10 to R12 applies.
- R14: A size of zero means XLEN/8 bytes; the last byte is address plus size minus one, wrapping modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | XLEN | First byte address |
| req_size | input | SIZE_W | Byte count, 0 means one word |
| req_perm | input | 3 | Wanted rights: bit 0 R, bit 1 W, bit 2 X |
| req_mach | input | 1 | Requester is at machine level |
| region_lo | input | ENTRIES*XLEN | Inclusive low bound per region |
| region_hi | input | ENTRIES*XLEN | Inclusive high bound per region |
| region_cfg | input | ENTRIES*6 | Per region: R, W, X, mode[1:0], lock |
| rule_count | input | CNT_W | Number of active regions |
| sec_lockdown | input | 1 | Selects the lockdown tables and default |
| sec_whitelist | input | 1 | Unmatched accesses are denied |
| resp_valid | output | 1 | Result strobe |
| resp_allow | output | 1 | Access may proceed |
| resp_perm | output | 3 | Rights mask that applied |

## Verification
The bench builds the block with XLEN of 32, four regions and a four-bit size field. Four regions are enough to stack overlapping and disabled regions in front of each other for the priority and skip cases, and a 32-bit address lets a request straddle the top of the address space to reach the wrap-around of R14. Both sixteen-row tables are swept completely at both privilege levels.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int CFG_W    = 6;
  localparam int CFG_R    = 0;
  localparam int CFG_W_B  = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_MLSB = 3;
  localparam int CFG_LOCK = 5;

  typedef logic [2:0] rights_t;

  localparam rights_t RT_NONE = 3'b000;
  localparam rights_t RT_R    = 3'b001;
  localparam rights_t RT_RW   = 3'b011;
  localparam rights_t RT_X    = 3'b100;
  localparam rights_t RT_RX   = 3'b101;
  localparam rights_t RT_RWX  = 3'b111;

  // Row number formed as lock, read, write, execute (msb to lsb).
  function automatic logic [3:0] row_of(input logic lock, input rights_t r);
    return {lock, r[0], r[1], r[2]};
  endfunction

  function automatic rights_t tbl_machine(input logic [3:0] row);
    case (row)
      4'd2, 4'd3, 4'd14: return RT_RW;
      4'd9, 4'd10:       return RT_X;
      4'd11, 4'd13:      return RT_RX;
      4'd12, 4'd15:      return RT_R;
      default:           return RT_NONE;
    endcase
  endfunction

  function automatic rights_t tbl_lower(input logic [3:0] row);
    case (row)
      4'd1, 4'd10, 4'd11: return RT_X;
      4'd2, 4'd4, 4'd15:  return RT_R;
      4'd3, 4'd6:         return RT_RW;
      4'd5:               return RT_RX;
      4'd7:               return RT_RWX;
      default:            return RT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pmp_region_probe.sv
module pmp_region_probe #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] first_b,
  input  logic [XLEN-1:0] last_b,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] hi,
  input  logic [1:0]      mode,
  output logic            hit,
  output logic            split
);
  logic in_first, in_last;

  always_comb begin
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b  >= lo) && (last_b  <= hi);
    split    = in_first ^ in_last;
    hit      = in_first && in_last && (mode != 2'b00);
  end
endmodule

// File: rtl/pmp_first_decider.sv
module pmp_first_decider #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hit,
  input  logic [ENTRIES-1:0] split,
  output logic               found,
  output logic               found_split,
  output logic [IDX_W-1:0]   found_idx
);
  always_comb begin
    found       = 1'b0;
    found_split = 1'b0;
    found_idx   = '0;
    // Walk downward so the lowest index is the last to overwrite.
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i] || split[i]) begin
        found       = 1'b1;
        found_split = split[i];
        found_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pmp_rule_perms.sv
module pmp_rule_perms
  import pmp_chk_pkg::*;
(
  input  logic    lock,
  input  rights_t own,
  input  logic    mach,
  input  logic    lockdown,
  output rights_t mask
);
  logic [3:0] row;

  always_comb begin
    row = row_of(lock, own);
    if (!lockdown)
      mask = (mach && !lock) ? RT_RWX : own;
    else if (mach)
      mask = tbl_machine(row);
    else
      mask = tbl_lower(row);
  end
endmodule

// File: rtl/pmp_default_policy.sv
module pmp_default_policy
  import pmp_chk_pkg::*;
(
  input  logic    mach,
  input  logic    want_x,
  input  logic    lockdown,
  input  logic    whitelist,
  output logic    allow,
  output rights_t mask
);
  always_comb begin
    allow = 1'b0;
    mask  = RT_NONE;
    if (whitelist) begin
      allow = 1'b0;
    end else if (lockdown) begin
      if (mach && !want_x) begin
        allow = 1'b1;
        mask  = RT_RW;
      end
    end else if (mach) begin
      allow = 1'b1;
      mask  = RT_RWX;
    end
  end
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 8,
  parameter int SIZE_W  = 4,
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [XLEN-1:0]         req_addr,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic [2:0]              req_perm,
  input  logic                    req_mach,
  input  logic [ENTRIES*XLEN-1:0] region_lo,
  input  logic [ENTRIES*XLEN-1:0] region_hi,
  input  logic [ENTRIES*CFG_W-1:0] region_cfg,
  input  logic [CNT_W-1:0]        rule_count,
  input  logic                    sec_lockdown,
  input  logic                    sec_whitelist,
  output logic                    resp_valid,
  output logic                    resp_allow,
  output logic [2:0]              resp_perm
);
  localparam int WORD_BYTES = XLEN / 8;

  logic [XLEN-1:0]    span;
  logic [XLEN-1:0]    last_b;
  logic [ENTRIES-1:0] hit_v, split_v;
  logic [ENTRIES-1:0] lock_v;
  rights_t            own_v [ENTRIES];

  always_comb begin
    span   = (req_size == '0) ? XLEN'(WORD_BYTES) : XLEN'(req_size);
    last_b = req_addr + span - XLEN'(1);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_region
    logic [CFG_W-1:0] cfg;
    assign cfg       = region_cfg[g*CFG_W +: CFG_W];
    assign lock_v[g] = cfg[CFG_LOCK];
    assign own_v[g]  = {cfg[CFG_X], cfg[CFG_W_B], cfg[CFG_R]};

    pmp_region_probe #(.XLEN(XLEN)) u_probe (
      .first_b (req_addr),
      .last_b  (last_b),
      .lo      (region_lo[g*XLEN +: XLEN]),
      .hi      (region_hi[g*XLEN +: XLEN]),
      .mode    (cfg[CFG_MLSB +: 2]),
      .hit     (hit_v[g]),
      .split   (split_v[g])
    );
  end

  logic             found, found_split;
  logic [IDX_W-1:0] found_idx;

  pmp_first_decider #(.ENTRIES(ENTRIES)) u_pick (
    .hit         (hit_v),
    .split       (split_v),
    .found       (found),
    .found_split (found_split),
    .found_idx   (found_idx)
  );

  rights_t rule_mask;

  pmp_rule_perms u_perm (
    .lock     (lock_v[found_idx]),
    .own      (own_v[found_idx]),
    .mach     (req_mach),
    .lockdown (sec_lockdown),
    .mask     (rule_mask)
  );

  logic    dflt_allow;
  rights_t dflt_mask;

  pmp_default_policy u_dflt (
    .mach      (req_mach),
    .want_x    (req_perm[2]),
    .lockdown  (sec_lockdown),
    .whitelist (sec_whitelist),
    .allow     (dflt_allow),
    .mask      (dflt_mask)
  );

  logic    nxt_allow;
  rights_t nxt_mask;

  always_comb begin
    if ((rule_count != '0) && found) begin
      if (found_split) begin
        nxt_allow = 1'b0;
        nxt_mask  = RT_NONE;
      end else begin
        nxt_allow = ((req_perm & ~rule_mask) == 3'b000);
        nxt_mask  = rule_mask;
      end
    end else begin
      nxt_allow = dflt_allow;
      nxt_mask  = dflt_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_perm  <= 3'b000;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_allow <= nxt_allow;
        resp_perm  <= nxt_mask;
      end
    end
  end
endmodule

// File: rtl/pmp_access_checker_sva.sv
module pmp_access_checker_sva #(
  parameter int XLEN    = 32,
  parameter int SIZE_W  = 4,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_perm,
  input logic              req_mach,
  input logic [CNT_W-1:0]  rule_count,
  input logic              sec_lockdown,
  input logic              sec_whitelist,
  input logic              resp_valid,
  input logic              resp_allow,
  input logic [2:0]        resp_perm
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && $stable(resp_allow) && $stable(resp_perm)));

  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (!resp_valid && !resp_allow && resp_perm == 3'b000));

  a_r9_pass_within_mask: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!resp_allow || (($past(req_perm) & ~resp_perm) == 3'b000)));

  a_r10_whitelist_denies: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rule_count == '0 && sec_whitelist) |=>
      (!resp_allow && resp_perm == 3'b000));

  a_r12_mach_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rule_count == '0 && !sec_whitelist && !sec_lockdown && req_mach) |=>
      (resp_allow && resp_perm == 3'b111));

  a_r13_lower_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rule_count == '0 && !req_mach) |=> !resp_allow);
endmodule

bind pmp_access_checker pmp_access_checker_sva #(
  .XLEN(XLEN), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_perm(req_perm),
  .req_mach(req_mach), .rule_count(rule_count), .sec_lockdown(sec_lockdown),
  .sec_whitelist(sec_whitelist), .resp_valid(resp_valid),
  .resp_allow(resp_allow), .resp_perm(resp_perm)
);

// File: tb/pmp_access_checker_test.sv
`timescale 1ns/1ps
module pmp_access_checker_test;
  localparam int XLEN = 32;
  localparam int ENT  = 4;
  localparam int SW   = 4;
  localparam int CW   = $clog2(ENT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            req_valid = 1'b0;
  logic [XLEN-1:0] req_addr  = '0;
  logic [SW-1:0]   req_size  = '0;
  logic [2:0]      req_perm  = '0;
  logic            req_mach  = 1'b0;
  logic [CW-1:0]   rule_count = '0;
  logic            sec_lockdown = 1'b0;
  logic            sec_whitelist = 1'b0;
  logic [XLEN-1:0] lo [ENT];
  logic [XLEN-1:0] hi [ENT];
  logic [5:0]      cf [ENT];
  logic [ENT*XLEN-1:0] region_lo, region_hi;
  logic [ENT*6-1:0]    region_cfg;
  logic            resp_valid, resp_allow;
  logic [2:0]      resp_perm;

  always_comb begin
    for (int i = 0; i < ENT; i++) begin
      region_lo[i*XLEN +: XLEN] = lo[i];
      region_hi[i*XLEN +: XLEN] = hi[i];
      region_cfg[i*6 +: 6]      = cf[i];
    end
  end

  pmp_access_checker #(.XLEN(XLEN), .ENTRIES(ENT), .SIZE_W(SW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mach(req_mach),
    .region_lo(region_lo), .region_hi(region_hi), .region_cfg(region_cfg),
    .rule_count(rule_count), .sec_lockdown(sec_lockdown),
    .sec_whitelist(sec_whitelist), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_perm(resp_perm));

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  string exp_tag = "R2";
  logic exp_v = 1'b0, exp_a = 1'b0;
  logic [2:0] exp_m = 3'b000;

  // Behavioural reference: returns {allow, mask}.
  function automatic logic [3:0] ref_model();
    longint unsigned n, last;
    int row;
    logic [2:0] m;
    logic fin, lin;
    n = (req_size == 0) ? XLEN / 8 : req_size;
    last = (longint'(req_addr) + n - 1) % (64'd1 << XLEN);
    if (rule_count != 0) begin
      for (int i = 0; i < ENT; i++) begin
        fin = (req_addr >= lo[i]) && (req_addr <= hi[i]);
        lin = (last >= lo[i]) && (last <= hi[i]);
        if (fin != lin) return 4'b0000;
        if (fin && cf[i][4:3] != 0) begin
          row = cf[i][5] * 8 + cf[i][0] * 4 + cf[i][1] * 2 + cf[i][2];
          if (!sec_lockdown) m = (req_mach && !cf[i][5]) ? 3'b111 : cf[i][2:0];
          else if (req_mach) begin
            if (row inside {2, 3, 14}) m = 3'b011;
            else if (row inside {9, 10}) m = 3'b100;
            else if (row inside {11, 13}) m = 3'b101;
            else if (row inside {12, 15}) m = 3'b001;
            else m = 3'b000;
          end else begin
            if (row inside {1, 10, 11}) m = 3'b100;
            else if (row inside {2, 4, 15}) m = 3'b001;
            else if (row inside {3, 6}) m = 3'b011;
            else if (row == 5) m = 3'b101;
            else if (row == 7) m = 3'b111;
            else m = 3'b000;
          end
          return {((req_perm & m) == req_perm), m};
        end
      end
    end
    if (sec_whitelist) return 4'b0000;
    if (sec_lockdown) return (req_mach && !req_perm[2]) ? 4'b1011 : 4'b0000;
    return req_mach ? 4'b1111 : 4'b0000;
  endfunction

  always @(posedge clk) begin
    logic [3:0] r;
    if (rst) begin
      exp_v <= 1'b0; exp_a <= 1'b0; exp_m <= 3'b000; exp_tag <= "R2";
    end else begin
      exp_v <= req_valid;
      if (req_valid) begin
        r = ref_model();
        exp_a <= r[3]; exp_m <= r[2:0]; exp_tag <= tag;
      end else exp_tag <= "R1";
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (resp_valid !== exp_v || resp_allow !== exp_a || resp_perm !== exp_m) begin
        errors++;
        $display("FAIL %s actual v=%b a=%b m=%b expected v=%b a=%b m=%b",
                 exp_tag, resp_valid, resp_allow, resp_perm, exp_v, exp_a, exp_m);
      end
    end
  end

  task automatic ask(string t, logic [XLEN-1:0] a, logic [SW-1:0] s,
                     logic [2:0] p, logic m);
    @(negedge clk);
    tag = t; req_valid = 1'b1; req_addr = a; req_size = s; req_perm = p; req_mach = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic region(int i, logic [XLEN-1:0] l, logic [XLEN-1:0] h, logic [5:0] c);
    lo[i] = l; hi[i] = h; cf[i] = c;
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) region(i, 32'hF000_0000, 32'hF000_00FF, 6'b0);
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || resp_allow !== 1'b0 || resp_perm !== 3'b000) begin
      errors++;
      $display("FAIL R2 actual v=%b a=%b m=%b expected 0 0 000", resp_valid, resp_allow, resp_perm);
    end
    rst = 1'b0;
    // Defaults with no active rules, region set up over the address (R13).
    region(0, 32'h1000, 32'h1FFF, 6'b0_01_001);
    ask("R12", 32'h1000, 4, 3'b111, 1'b1);
    ask("R12", 32'h1000, 4, 3'b001, 1'b0);
    ask("R13", 32'h1004, 4, 3'b010, 1'b1);
    // Standard flavour.
    rule_count = 1;
    ask("R6", 32'h1000, 4, 3'b010, 1'b1);
    ask("R6", 32'h1000, 4, 3'b010, 1'b0);
    ask("R9", 32'h1000, 4, 3'b001, 1'b0);
    ask("R9", 32'h1000, 4, 3'b000, 1'b0);
    region(0, 32'h1000, 32'h1FFF, 6'b1_01_001);
    ask("R6", 32'h1000, 4, 3'b010, 1'b1);
    // Priority and skipping.
    rule_count = 2;
    region(0, 32'h1000, 32'h1FFF, 6'b0_01_001);
    region(1, 32'h1000, 32'h10FF, 6'b0_01_011);
    ask("R3", 32'h1010, 4, 3'b010, 1'b0);
    region(0, 32'h1000, 32'h1FFF, 6'b0_00_001);
    ask("R5", 32'h1010, 4, 3'b010, 1'b0);
    ask("R5", 32'h1200, 4, 3'b001, 1'b0);
    // Partial overlap, also on a disabled region.
    region(0, 32'h1000, 32'h1FFF, 6'b0_01_111);
    ask("R4", 32'h1FFE, 4, 3'b001, 1'b1);
    region(0, 32'h1000, 32'h1FFF, 6'b0_00_111);
    ask("R4", 32'h0FFE, 4, 3'b001, 1'b1);
    // Size zero and wrap-around.
    region(0, 32'h1000, 32'h1FFF, 6'b0_01_001);
    ask("R14", 32'h1FFC, 0, 3'b001, 1'b0);
    ask("R14", 32'h1FFE, 0, 3'b001, 1'b0);
    region(0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 6'b0_01_111);
    ask("R14", 32'hFFFF_FFFE, 4, 3'b001, 1'b0);
    ask("R14", 32'hFFFF_FFFC, 4, 3'b001, 1'b0);
    // Lockdown tables.
    rule_count = 1;
    sec_lockdown = 1'b1;
    for (int k = 0; k < 16; k++) begin
      region(0, 32'h1000, 32'h1FFF, {k[3], 2'b01, k[0], k[1], k[2]});
      ask("R7", 32'h1000, 4, 3'b111, 1'b1);
      ask("R8", 32'h1000, 4, 3'b001, 1'b0);
    end
    // Lockdown default, unmatched address and empty rule set.
    ask("R11", 32'h8000, 4, 3'b011, 1'b1);
    ask("R11", 32'h8000, 4, 3'b100, 1'b1);
    ask("R11", 32'h8000, 4, 3'b001, 1'b0);
    rule_count = 0;
    ask("R11", 32'h1000, 4, 3'b001, 1'b1);
    // Restrictive default.
    sec_whitelist = 1'b1;
    ask("R10", 32'h1000, 4, 3'b001, 1'b1);
    sec_lockdown = 1'b0;
    rule_count = 1;
    ask("R10", 32'h8000, 4, 3'b000, 1'b1);
    sec_whitelist = 1'b0;
    // Idle cycles must hold the last result.
    tag = "R1";
    repeat (4) @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule